// File: doc/BRIEF.md
# Frame Buffer Display Scan-Out Controller

This block drives a 640x480 true-colour panel from a frame held in external memory. A free-running timing generator produces the line and frame cadence. A fetch engine reads one 32-bit word per visible pixel through a simple request/ready read port and parks the returned words in a small prefetch buffer. An output stage registers the colour, the two syncs and the data-enable together, so all of them appear on the same clock.

Software sees two 32-bit registers. The first holds the frame base address, which is coarsely aligned. The second holds an enable bit and a rotate bit. With rotate set, the engine walks memory backwards: last row first, and within each row the last word first. The displayed image is therefore turned by 180 degrees without any change to the stored frame. Register changes are picked up once per frame, on the first clock of the final blanking line. This gives the fetch engine that whole line to prefetch before row 0, and it keeps a frame from being torn.

The timing numbers, the row stride, the base alignment and the buffer depth are parameters. The defaults give the standard 60 Hz 640x480 timing with a 1024-word row pitch.

Top module: `fb_scanout`

## Requirements
- R1: A line is 800 clocks long. hsync_n is low for 96 clocks, starting 16 clocks after the last visible pixel of the line. vsync_n is low for 2 whole lines of the 525-line frame. Both syncs are active-low and keep running in every mode.
- R2: In an enabled frame, de is high for exactly 640 consecutive clocks on each of 480 rows. de is never high while either sync is low.
- R3: For each pixel, rgb_r carries bits 23:16 of the fetched word, rgb_g carries bits 15:8 and rgb_b carries bits 7:0. Bits 31:24 of the word have no effect on the output.
- R4: With rotate clear, visible pixel (row r, column c) comes from byte address base + 4*(r*1024 + c), and pixels leave in scan order. Words 640..1023 of each row are never requested.
- R5: With rotate set (control bit 1), visible pixel (r, c) comes from the word that the unrotated scan would show at (479-r, 639-c).
- R6: The base register sits at byte offset 0. It keeps only bits 31:21 of a write and reads back with bits 20:0 as zero, so a frame always starts on a 2 MiB boundary.
- R7: The control register sits at byte offset 4, with bit 0 = enable and bit 1 = rotate. It reads back with bits 31:2 as zero. Writes to any other offset are ignored, and reads from any other offset return zero.
- R8: While the frame in progress is disabled, de stays low, all colour outputs are zero and mem_req stays low. A control value of zero blanks the display from the next frame on.
- R9: Base, enable and rotate are captured only on the first clock of the last line of each frame. A register write in the middle of a frame leaves the rest of that frame unchanged.
- R10: Once mem_req is raised, it stays high with a stable mem_addr until mem_ready accepts it. Words requested but not yet returned, plus words buffered, never exceed the buffer depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset (0 = base, 4 = control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Read request valid |
| mem_ready | input | 1 | Memory accepts the request this clock |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data returned this clock, in request order |
| mem_rdata | input | 32 | Returned pixel word |
| rgb_r | output | 8 | Red level |
| rgb_g | output | 8 | Green level |
| rgb_b | output | 8 | Blue level |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Visible-pixel qualifier |

## Verification
The assertions take for granted that memory returns words in request order and keeps pace with the display. Under that assumption, every word of an enabled frame has arrived and been consumed before the next capture point, the prefetch buffer is drained at each capture, and a stalled request is never abandoned. The bench memory model answers every accepted request after a fixed short delay, in order. It withholds ready on one clock out of four, so stalls still occur while the average fetch rate stays well above the pixel rate. The bench also shrinks the geometry and the row stride through parameters and writes registers only inside vertical blanking. The one exception is a single deliberate mid-frame write.

// File: rtl/fbscan_pkg.sv
// Shared widths and the per-frame configuration record of the scan-out block.
// Assumes a 32-bit register and memory data path.
package fbscan_pkg;
    parameter int FB_AW = 32;   // byte address width
    parameter int FB_DW = 32;   // memory / register word width

    typedef struct packed {
        logic [FB_AW-1:0] base;  // aligned frame base (byte address)
        logic             rot;   // 180-degree walk
        logic             en;    // display on
    } fb_cfg_t;
endpackage

// File: rtl/fbscan_timing.sv
// Free-running raster counters for one fixed video mode.
// Assumes all porch/sync lengths are at least 1; syncs are whole-line for vertical.
module fbscan_timing #(
    parameter int H_ACTIVE = 640,
    parameter int H_FRONT  = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BACK   = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FRONT  = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 33
) (
    input  logic clk,
    input  logic rst_n,
    output logic pix_active,
    output logic hsync_act,
    output logic vsync_act,
    output logic frame_latch
);
    localparam int HTOT = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
    localparam int VTOT = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
    localparam int HW   = $clog2(HTOT);
    localparam int VW   = $clog2(VTOT);
    localparam logic [HW-1:0] H_LAST = HW'(HTOT - 1);
    localparam logic [HW-1:0] H_VIS  = HW'(H_ACTIVE);
    localparam logic [HW-1:0] H_S0   = HW'(H_ACTIVE + H_FRONT);
    localparam logic [HW-1:0] H_S1   = HW'(H_ACTIVE + H_FRONT + H_SYNC);
    localparam logic [VW-1:0] V_LAST = VW'(VTOT - 1);
    localparam logic [VW-1:0] V_VIS  = VW'(V_ACTIVE);
    localparam logic [VW-1:0] V_S0   = VW'(V_ACTIVE + V_FRONT);
    localparam logic [VW-1:0] V_S1   = VW'(V_ACTIVE + V_FRONT + V_SYNC);

    logic [HW-1:0] hcnt_q;
    logic [VW-1:0] vcnt_q;

    // Advance the pixel and line counters, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q <= '0;
            vcnt_q <= '0;
        end else if (hcnt_q == H_LAST) begin
            hcnt_q <= '0;
            vcnt_q <= (vcnt_q == V_LAST) ? '0 : vcnt_q + 1'b1;
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    // Decode visible area, sync windows and the per-frame capture point.
    always_comb begin
        pix_active  = (hcnt_q < H_VIS) && (vcnt_q < V_VIS);
        hsync_act   = (hcnt_q >= H_S0) && (hcnt_q < H_S1);
        vsync_act   = (vcnt_q >= V_S0) && (vcnt_q < V_S1);
        frame_latch = (vcnt_q == V_LAST) && (hcnt_q == '0);
    end

    a_r1_sync_outside_active: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_act || vsync_act) |-> !pix_active);
endmodule

// File: rtl/fbscan_regs.sv
// Software-visible base and control registers plus the frame-synchronous copy.
// Assumes single-cycle writes; only byte offsets 0 and 4 decode.
module fbscan_regs
    import fbscan_pkg::*;
#(
    parameter int BASE_KEEP = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [FB_DW-1:0] reg_wdata,
    output logic [FB_DW-1:0] reg_rdata,
    input  logic             frame_latch,
    output fb_cfg_t          cfg_q
);
    localparam int LOW = FB_AW - BASE_KEEP;

    logic [FB_AW-1:0] base_q;
    logic             en_q;
    logic             rot_q;
    logic             sel_base;
    logic             sel_ctrl;

    assign sel_base = (reg_addr == 3'd0);
    assign sel_ctrl = (reg_addr == 3'd4);

    // Store software writes; the base keeps only its top bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= 1'b0;
            rot_q  <= 1'b0;
        end else if (reg_we) begin
            if (sel_base) base_q <= {reg_wdata[FB_DW-1 -: BASE_KEEP], {LOW{1'b0}}};
            if (sel_ctrl) begin
                en_q  <= reg_wdata[0];
                rot_q <= reg_wdata[1];
            end
        end
    end

    // Read-back multiplexer.
    always_comb begin
        if (sel_base)      reg_rdata = base_q;
        else if (sel_ctrl) reg_rdata = {{(FB_DW-2){1'b0}}, rot_q, en_q};
        else               reg_rdata = '0;
    end

    // Copy the programmed values into the live frame configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)           cfg_q <= '0;
        else if (frame_latch) cfg_q <= '{base: base_q, rot: rot_q, en: en_q};
    end

    a_r6_base_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sel_base |-> (reg_rdata[LOW-1:0] == '0));
    a_r7_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctrl |-> (reg_rdata[FB_DW-1:2] == '0));
endmodule

// File: rtl/fbscan_fetch.sv
// Address walker and prefetch buffer: requests each visible word of the frame
// once, in scan or reversed order, and buffers returned colour bits.
// Assumes in-order read returns and a memory that keeps pace with the display.
module fbscan_fetch
    import fbscan_pkg::*;
#(
    parameter int H_ACTIVE   = 640,
    parameter int V_ACTIVE   = 480,
    parameter int ROW_STRIDE = 1024,
    parameter int FIFO_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fb_cfg_t          cfg,
    input  logic             frame_latch,
    input  logic             pop,
    output logic             mem_req,
    input  logic             mem_ready,
    output logic [FB_AW-1:0] mem_addr,
    input  logic             mem_rvalid,
    input  logic [FB_DW-1:0] mem_rdata,
    output logic [23:0]      head,
    output logic             empty
);
    localparam int CW = $clog2(H_ACTIVE);
    localparam int RW = $clog2(V_ACTIVE);
    localparam int PW = $clog2(FIFO_DEPTH);
    localparam logic [CW-1:0] COL_LAST = CW'(H_ACTIVE - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(V_ACTIVE - 1);

    logic [CW-1:0]    col_q;
    logic [RW-1:0]    row_q;
    logic             done_q;
    logic [PW:0]      wp_q, rp_q, inflight_q, count;
    logic [PW+1:0]    occupancy;
    logic [23:0]      buf_q [FIFO_DEPTH];
    logic [CW-1:0]    col_m;
    logic [RW-1:0]    row_m;
    logic [FB_AW-1:0] offs;
    logic             acc;
    logic             unused_pad;

    assign unused_pad = ^mem_rdata[FB_DW-1:24];

    // Request decision and address mapping (forward or reversed walk).
    always_comb begin
        count     = wp_q - rp_q;
        occupancy = {1'b0, count} + {1'b0, inflight_q};
        mem_req   = cfg.en && !done_q && !frame_latch && (occupancy < (PW+2)'(FIFO_DEPTH));
        acc       = mem_req && mem_ready;
        col_m     = cfg.rot ? COL_LAST - col_q : col_q;
        row_m     = cfg.rot ? ROW_LAST - row_q : row_q;
        offs      = FB_AW'(row_m) * FB_AW'(ROW_STRIDE) + FB_AW'(col_m);
        mem_addr  = cfg.base + {offs[FB_AW-3:0], 2'b00};
        empty     = (count == '0);
        head      = buf_q[rp_q[PW-1:0]];
    end

    // Step through visible columns and rows on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            row_q  <= '0;
            done_q <= 1'b1;
        end else if (frame_latch) begin
            col_q  <= '0;
            row_q  <= '0;
            done_q <= 1'b0;
        end else if (acc) begin
            if (col_q == COL_LAST) begin
                col_q <= '0;
                if (row_q == ROW_LAST) done_q <= 1'b1;
                else                   row_q  <= row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    // Capture returned colour bits into the buffer.
    always_ff @(posedge clk) begin
        if (mem_rvalid) buf_q[wp_q[PW-1:0]] <= mem_rdata[23:0];
    end

    // Track buffer pointers and words still in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q       <= '0;
            rp_q       <= '0;
            inflight_q <= '0;
        end else begin
            wp_q       <= wp_q + (PW+1)'(mem_rvalid);
            rp_q       <= rp_q + (PW+1)'(pop && !empty);
            inflight_q <= inflight_q + (PW+1)'(acc) - (PW+1)'(mem_rvalid);
        end
    end

    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> (count < (PW+1)'(FIFO_DEPTH)));
    a_r9_drained_at_capture: assert property (@(posedge clk) disable iff (!rst_n)
        frame_latch |-> (inflight_q == '0 && count == '0));
endmodule

// File: rtl/fb_scanout.sv
// Top of the frame buffer scan-out controller: timing, registers, fetch and a
// single aligned output register stage for colour, syncs and data-enable.
// Assumes memory returns words in order and fast enough for the pixel rate.
module fb_scanout
    import fbscan_pkg::*;
#(
    parameter int H_ACTIVE   = 640,
    parameter int H_FRONT    = 16,
    parameter int H_SYNC     = 96,
    parameter int H_BACK     = 48,
    parameter int V_ACTIVE   = 480,
    parameter int V_FRONT    = 10,
    parameter int V_SYNC     = 2,
    parameter int V_BACK     = 33,
    parameter int ROW_STRIDE = 1024,
    parameter int BASE_KEEP  = 11,
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    input  logic        mem_ready,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic [7:0]  rgb_r,
    output logic [7:0]  rgb_g,
    output logic [7:0]  rgb_b,
    output logic        hsync_n,
    output logic        vsync_n,
    output logic        de
);
    logic        pix_active, hsync_act, vsync_act, frame_latch;
    logic        pop, empty;
    logic [23:0] head;
    fb_cfg_t     cfg;

    fbscan_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
        .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .pix_active(pix_active), .hsync_act(hsync_act),
        .vsync_act(vsync_act), .frame_latch(frame_latch)
    );

    fbscan_regs #(.BASE_KEEP(BASE_KEEP)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_latch(frame_latch),
        .cfg_q(cfg)
    );

    fbscan_fetch #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .ROW_STRIDE(ROW_STRIDE),
        .FIFO_DEPTH(FIFO_DEPTH)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .frame_latch(frame_latch), .pop(pop),
        .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .head(head), .empty(empty)
    );

    assign pop = pix_active && cfg.en;

    // Register all display outputs together so they leave on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de                    <= 1'b0;
            {rgb_r, rgb_g, rgb_b} <= '0;
            hsync_n               <= 1'b1;
            vsync_n               <= 1'b1;
        end else begin
            de                    <= pop;
            {rgb_r, rgb_g, rgb_b} <= (pop && !empty) ? head : 24'h0;
            hsync_n               <= !hsync_act;
            vsync_n               <= !vsync_act;
        end
    end

    a_r2_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync_n && vsync_n));
    a_r8_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> ({rgb_r, rgb_g, rgb_b} == 24'h0));
    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> (!mem_req && !de));
endmodule

// File: tb/fb_scanout_test.sv
// Scoreboard bench: the driver pushes the expected colour of every visible
// pixel per frame; a monitor pops and compares as de runs.
module fb_scanout_test;
    localparam int HA = 4, HF = 2, HS = 3, HB = 3;
    localparam int VA = 3, VF = 1, VS = 2, VB = 2;
    localparam int HTOT = HA + HF + HS + HB;
    localparam int VTOT = VA + VF + VS + VB;
    localparam int STRIDE = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mem_req, mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic [7:0] rgb_r, rgb_g, rgb_b;
    logic hsync_n, vsync_n, de;

    int checks = 0, errors = 0;
    logic [23:0] exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    fb_scanout #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
        .ROW_STRIDE(STRIDE), .BASE_KEEP(11), .FIFO_DEPTH(8)
    ) uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input logic [31:0] a);
        logic [31:0] w;
        w = a >> 2;
        return {8'hC3, w[7:0] ^ 8'h5A, w[15:8] + 8'h21, w[23:16] ^ 8'h3C};
    endfunction

    task automatic push_frame(input logic [31:0] base, input bit rot);
        logic [31:0] mb;
        mb = base & 32'hFFE0_0000;
        for (int r = 0; r < VA; r++)
            for (int c = 0; c < HA; c++) begin
                int rr, cc;
                rr = rot ? VA - 1 - r : r;
                cc = rot ? HA - 1 - c : c;
                exp_q.push_back(word_at(mb + 32'(4 * (rr * STRIDE + cc)))[23:0]);
            end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_vs();
        logic p;
        p = vsync_n;
        forever begin
            @(negedge clk);
            if (p && !vsync_n) break;
            p = vsync_n;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Memory model: in-order replies two stages after acceptance, ready gaps.
    int req_count = 0, rc = 0;
    logic st0_v = 1'b0, st1_v = 1'b0, stall = 1'b0;
    logic [31:0] st0_a = '0, st1_a = '0, stall_a = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0; mem_rvalid = 1'b0; st0_v = 1'b0; st1_v = 1'b0; stall = 1'b0;
        end else begin
            if (stall) chk(mem_req && mem_addr == stall_a, "R10", "stalled request held", mem_addr, stall_a);
            mem_rvalid = st1_v;
            mem_rdata  = word_at(st1_a);
            st1_v = st0_v; st1_a = st0_a; st0_v = 1'b0;
            rc++;
            mem_ready = (rc % 4) != 3;
            if (mem_req) begin
                req_count++;
                if (mem_ready) begin
                    st0_v = 1'b1; st0_a = mem_addr;
                    chk(((mem_addr >> 2) % STRIDE) < HA, "R4", "stride gap not fetched", mem_addr, 0);
                end
            end
            stall   = mem_req && !mem_ready;
            stall_a = mem_addr;
        end
    end

    // Monitor: pixel scoreboard, de run lengths and sync geometry.
    int cyc = 0, run = 0, de_total = 0, hs_falls = 0;
    int hs_last = 0, vs_last = 0, de_fall = 0;
    bit hs_seen = 0, vs_seen = 0, armed = 0;
    logic p_de = 1'b0, p_hs = 1'b1, p_vs = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (de) begin
                de_total++; run++;
                chk(hsync_n && vsync_n, "R2", "de inside sync", {hsync_n, vsync_n}, 2'b11);
                if (exp_q.size() == 0) chk(0, "R9", "unexpected pixel", {rgb_r, rgb_g, rgb_b}, 0);
                else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    chk({rgb_r, rgb_g, rgb_b} == e, "R3 R4 R5", "pixel colour", {rgb_r, rgb_g, rgb_b}, e);
                end
            end else begin
                chk({rgb_r, rgb_g, rgb_b} == 0, "R8", "black outside de", {rgb_r, rgb_g, rgb_b}, 0);
                if (p_de) begin
                    chk(run == HA, "R2", "de run length", run, HA);
                    run = 0; de_fall = cyc; armed = 1;
                end
            end
            if (p_hs && !hsync_n) begin
                hs_falls++;
                if (hs_seen) chk(cyc - hs_last == HTOT, "R1", "line period", cyc - hs_last, HTOT);
                if (armed) begin
                    chk(cyc - de_fall == HF, "R1", "front porch", cyc - de_fall, HF);
                    armed = 0;
                end
                hs_last = cyc; hs_seen = 1;
            end
            if (!p_hs && hsync_n && hs_seen) chk(cyc - hs_last == HS, "R1", "hsync width", cyc - hs_last, HS);
            if (p_vs && !vsync_n) begin
                if (vs_seen) chk(cyc - vs_last == HTOT * VTOT, "R1", "frame period", cyc - vs_last, HTOT * VTOT);
                vs_last = cyc; vs_seen = 1;
            end
            if (!p_vs && vsync_n && vs_seen) chk(cyc - vs_last == HTOT * VS, "R1", "vsync width", cyc - vs_last, HTOT * VS);
            p_de = de; p_hs = hsync_n; p_vs = vsync_n;
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        chk(0, "watchdog", "run did not finish", 0, 1);
        finish_run();
    end

    // Driver.
    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!de && !mem_req && hsync_n && vsync_n && {rgb_r, rgb_g, rgb_b} == 0, "R8", "reset state",
            {de, mem_req, hsync_n, vsync_n}, 4'b0011);

        reg_write(3'd0, 32'h1234_5678);
        reg_read(3'd0, v);  chk(v == 32'h1220_0000, "R6", "base masked", v, 32'h1220_0000);
        reg_write(3'd4, 32'hFFFF_FFFF);
        reg_read(3'd4, v);  chk(v == 32'h3, "R7", "ctrl readback", v, 3);
        reg_write(3'd4, 32'hFFFF_FFFC);
        reg_read(3'd4, v);  chk(v == 32'h0, "R7", "ctrl cleared", v, 0);
        reg_write(3'd2, 32'hFFFF_FFFF);
        reg_read(3'd2, v);  chk(v == 32'h0, "R7", "unmapped offset", v, 0);
        reg_read(3'd0, v);  chk(v == 32'h1220_0000, "R7", "base kept after unmapped write", v, 32'h1220_0000);
        chk(de_total == 0 && req_count == 0, "R8", "idle while disabled", de_total + req_count, 0);

        wait_vs();
        reg_write(3'd0, 32'h0020_0000); reg_write(3'd4, 32'h1);
        push_frame(32'h0020_0000, 0);                       // R4 forward scan
        wait_vs();
        reg_write(3'd4, 32'h3);
        push_frame(32'h0020_0000, 1);                       // R5 reversed scan
        wait_vs();
        reg_write(3'd0, 32'h8FE1_2345); reg_write(3'd4, 32'h1);
        push_frame(32'h8FE1_2345, 0);
        do @(negedge clk); while (!de);
        reg_write(3'd0, 32'h4000_0000); reg_write(3'd4, 32'h3);  // R9 mid-frame write
        wait_vs();
        push_frame(32'h4000_0000, 1);
        wait_vs();
        reg_write(3'd4, 32'h0);                             // R8 blank next frame
        wait_vs();
        req_count = 0; de_total = 0; hs_falls = 0;
        wait_vs();
        chk(req_count == 0, "R8", "no requests while off", req_count, 0);
        chk(de_total == 0, "R8", "no de while off", de_total, 0);
        chk(hs_falls == VTOT, "R1", "hsync runs while off", hs_falls, VTOT);
        chk(exp_q.size() == 0, "R4", "all expected pixels shown", exp_q.size(), 0);
        finish_run();
    end
endmodule